// File: doc/BRIEF.md
# Synchronous Tag RAM with Comparator

This block is a single-port synchronous tag store for cache lookup. Each clock edge captures an address, a data word and a set of control inputs. Two opposite-polarity selects, a write strobe and a data-load strobe make up the controls. When the device is selected, the captured address is either written with the held data word or read back onto the data output.

A comparator works in the same cycle as the access. It checks the held data word against the word stored at the captured address. Its one-bit result passes through two register stages before it reaches the hit output. The data output and the hit output each have an unclocked enable. When an enable is off, its output is released to high impedance.

The depth is set by `AW` (`AW` = 16 gives 65,536 words) and the word width by `DW`, which defaults to 18. The default depth is kept small so that elaboration stays light.

Top module: `tagram_cmp`

## Requirements
- R1: A synchronous active-high `rst` clears the held data word, the read register and both hit stages. With the enables on, `rdata` reads 0 and `hit` reads 0 after the reset edge.
- R2: The device is selected only when `sel_n` = 0 and `sel_p` = 1 at the clock edge. A deselected cycle writes nothing and leaves `rdata` unchanged.
- R3: A selected cycle with `wr_n` = 0 stores the held data word at the captured address on the next clock edge.
- R4: A selected cycle with `wr_n` = 1 is a read. The stored word appears on `rdata` one edge after the edge that captured the request. Write and deselected cycles leave `rdata` unchanged.
- R5: The held data word loads `din` only on a selected edge with `dld_n` = 0, and otherwise keeps its value. A write with `dld_n` = 1 stores the previously held word.
- R6: On a selected cycle, `hit` becomes 1 exactly when the held data word equals the word stored at the captured address. It is presented two edges after the capturing edge.
- R7: A deselected cycle loads 0 into the hit pipeline, whatever the data word.
- R8: A compare in the cycle after a write to the same address sees the newly written word. The compare made in the write cycle itself sees the contents from before that write.
- R9: `qen_n` = 1 releases `rdata` and `men_n` = 1 releases `hit`. Each enable acts without waiting for a clock edge.
- R10: Reset leaves the array contents intact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | AW | Word address, captured each edge |
| din | input | DW | Write data and compare operand |
| sel_n | input | 1 | Active-low select |
| sel_p | input | 1 | Active-high select |
| wr_n | input | 1 | Active-low write strobe |
| dld_n | input | 1 | Active-low data-load strobe |
| qen_n | input | 1 | Active-low unclocked enable for `rdata` |
| men_n | input | 1 | Active-low unclocked enable for `hit` |
| rdata | output | DW | Read data, high impedance when disabled |
| hit | output | 1 | Compare result, high impedance when disabled |

## Verification
A corrupted held data word shows up at the ports in two ways. A later read of the address it was written to returns the wrong value, one edge after that read is captured. The hit result of every compare that uses the word also goes wrong, two edges after capture. A stale or mis-staged hit register shows as a hit that is one cycle early or late, or as a 1 after a deselected cycle, so each of these is caught on the cycle it happens. A wrong array word stays hidden until that address is read or compared; for this reason the bench first fills the whole array and then reads and compares throughout the run.

// File: rtl/tagram_pkg.sv
package tagram_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    function automatic logic is_selected(input logic sel_n, input logic sel_p);
        return (!sel_n) && sel_p;
    endfunction

    function automatic op_e decode_op(input logic sel_n, input logic sel_p, input logic wr_n);
        if (!is_selected(sel_n, sel_p)) return OP_IDLE;
        return wr_n ? OP_READ : OP_WRITE;
    endfunction

    function automatic logic loads_word(input logic sel_n, input logic sel_p, input logic dld_n);
        return is_selected(sel_n, sel_p) && !dld_n;
    endfunction

endpackage

// File: rtl/tag_in_stage.sv
module tag_in_stage
    import tagram_pkg::*;
#(
    parameter int AW = 10,
    parameter int DW = 18
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    input  logic          sel_n,
    input  logic          sel_p,
    input  logic          wr_n,
    input  logic          dld_n,
    output op_e           op_q,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] word_q
);

    logic load_w;
    assign load_w = loads_word(sel_n, sel_p, dld_n);

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q   <= OP_IDLE;
            addr_q <= '0;
            word_q <= '0;
        end else begin
            op_q   <= decode_op(sel_n, sel_p, wr_n);
            addr_q <= addr;
            if (load_w) word_q <= din;
        end
    end

    // R5: the held word keeps its value unless a selected load is requested
    assert_word_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !load_w |=> $stable(word_q));

endmodule

// File: rtl/tag_array.sv
module tag_array
    import tagram_pkg::*;
#(
    parameter int AW = 10,
    parameter int DW = 18
) (
    input  logic          clk,
    input  logic          rst,
    input  op_e           op_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] word_i,
    output logic [DW-1:0] rd_q,
    output logic          cmp_q
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] stored_w;
    logic          eq_w;

    assign stored_w = mem[addr_i];
    assign eq_w     = (stored_w == word_i);

    // array has no reset: contents survive rst
    always_ff @(posedge clk) begin
        if (!rst && op_i == OP_WRITE) mem[addr_i] <= word_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q  <= '0;
            cmp_q <= 1'b0;
        end else begin
            if (op_i == OP_READ) rd_q <= stored_w;
            cmp_q <= (op_i != OP_IDLE) && eq_w;
        end
    end

    // R3: a write lands the held word at the captured address
    assert_write_lands_R3: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_WRITE) |=> (mem[$past(addr_i)] == $past(word_i)));

    // R4: only reads move the read register
    assert_read_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (op_i != OP_READ) |=> $stable(rd_q));

endmodule

// File: rtl/tag_match_pipe.sv
module tag_match_pipe (
    input  logic clk,
    input  logic rst,
    input  logic cmp_i,
    output logic match_q
);

    always_ff @(posedge clk) begin
        if (rst) match_q <= 1'b0;
        else     match_q <= cmp_i;
    end

endmodule

// File: rtl/tagram_cmp.sv
module tagram_cmp
    import tagram_pkg::*;
#(
    parameter int AW = 10,
    parameter int DW = 18
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    input  logic          sel_n,
    input  logic          sel_p,
    input  logic          wr_n,
    input  logic          dld_n,
    input  logic          qen_n,
    input  logic          men_n,
    output logic [DW-1:0] rdata,
    output logic          hit
);

    op_e           op_w;
    logic [AW-1:0] addr_w;
    logic [DW-1:0] word_w;
    logic [DW-1:0] rd_w;
    logic          cmp_w;
    logic          match_w;

    tag_in_stage #(.AW(AW), .DW(DW)) u_in (
        .clk(clk), .rst(rst), .addr(addr), .din(din),
        .sel_n(sel_n), .sel_p(sel_p), .wr_n(wr_n), .dld_n(dld_n),
        .op_q(op_w), .addr_q(addr_w), .word_q(word_w)
    );

    tag_array #(.AW(AW), .DW(DW)) u_arr (
        .clk(clk), .rst(rst), .op_i(op_w), .addr_i(addr_w), .word_i(word_w),
        .rd_q(rd_w), .cmp_q(cmp_w)
    );

    tag_match_pipe u_pipe (
        .clk(clk), .rst(rst), .cmp_i(cmp_w), .match_q(match_w)
    );

    assign rdata = qen_n ? {DW{1'bz}} : rd_w;
    assign hit   = men_n ? 1'bz : match_w;

    // R1: reset empties read register and hit pipeline
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (rd_w == '0 && match_w == 1'b0));

    // R7: a deselected request never yields a hit two edges later
    assert_desel_nohit_R7: assert property (@(posedge clk) disable iff (rst)
        !is_selected(sel_n, sel_p) |=> ##2 !match_w);

endmodule

// File: tb/test_tagram_cmp.sv
module test_tagram_cmp;
    import tagram_pkg::*;

    localparam int AW = 10;
    localparam int DW = 18;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] addr;
    logic [DW-1:0] din;
    logic          sel_n, sel_p, wr_n, dld_n, qen_n, men_n;
    wire  [DW-1:0] rdata;
    wire           hit;

    always #4 clk = ~clk;

    tagram_cmp #(.AW(AW), .DW(DW)) i_tagram_cmp (
        .clk(clk), .rst(rst), .addr(addr), .din(din),
        .sel_n(sel_n), .sel_p(sel_p), .wr_n(wr_n), .dld_n(dld_n),
        .qen_n(qen_n), .men_n(men_n), .rdata(rdata), .hit(hit)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model state
    logic [DW-1:0] m_mem [DEPTH];
    bit            m_sel, m_wr;
    logic [AW-1:0] m_addr;
    logic [DW-1:0] m_word, m_rd;
    bit            m_cmp, m_match;

    function automatic bit q_off(input logic [DW-1:0] v);
        return (v === {DW{1'bz}}) || (v === '0);
    endfunction

    function automatic bit m_off(input logic v);
        return (v === 1'bz) || (v === 1'b0);
    endfunction

    task automatic chk_q(input string tag, input logic [DW-1:0] exp);
        checks++;
        if (rdata !== exp) begin
            errors++;
            $display("FAIL %s rdata=%h expected %h", tag, rdata, exp);
        end
    endtask

    task automatic chk_m(input string tag, input logic exp);
        checks++;
        if (hit !== exp) begin
            errors++;
            $display("FAIL %s hit=%b expected %b", tag, hit, exp);
        end
    endtask

    task automatic chk_q_off(input string tag);
        checks++;
        if (!q_off(rdata)) begin
            errors++;
            $display("FAIL %s rdata=%h expected released (z)", tag, rdata);
        end
    endtask

    task automatic chk_m_off(input string tag);
        checks++;
        if (!m_off(hit)) begin
            errors++;
            $display("FAIL %s hit=%b expected released (z)", tag, hit);
        end
    endtask

    task automatic model_edge();
        bit            n_cmp;
        logic [DW-1:0] n_rd;
        if (rst) begin
            m_sel = 0; m_wr = 0; m_addr = '0; m_word = '0;
            m_rd = '0; m_cmp = 0; m_match = 0;
        end else begin
            m_match = m_cmp;
            n_cmp = m_sel && (m_word == m_mem[m_addr]);
            n_rd  = (m_sel && !m_wr) ? m_mem[m_addr] : m_rd;
            if (m_sel && m_wr) m_mem[m_addr] = m_word;
            m_cmp = n_cmp;
            m_rd  = n_rd;
            m_sel = is_selected(sel_n, sel_p);
            m_wr  = !wr_n;
            m_addr = addr;
            if (m_sel && !dld_n) m_word = din;
        end
    endtask

    task automatic tick(input string tq, input string tm);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        if (!qen_n) chk_q(tq, m_rd); else chk_q_off("R9");
        if (!men_n) chk_m(tm, m_match); else chk_m_off("R9");
    endtask

    task automatic drive(input bit sel, input bit wr, input int a,
                         input logic [DW-1:0] d, input bit ld);
        sel_n = !sel; sel_p = sel;
        wr_n = !wr; addr = a[AW-1:0]; din = d; dld_n = !ld;
    endtask

    task automatic idle(input string tq, input string tm);
        drive(0, 0, 0, '0, 0);
        tick(tq, tm);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL R4 watchdog: actual hung run, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] w;
        void'($urandom(32'd20240611));
        rst = 1; qen_n = 0; men_n = 0;
        drive(0, 0, 0, '0, 0);
        @(negedge clk);
        tick("R1", "R1");
        tick("R1", "R1");
        rst = 0;

        // fill the array
        for (int a = 0; a < DEPTH; a++) begin
            drive(1, 1, a, DW'($urandom), 1);
            tick("R3", "R6");
        end
        idle("R3", "R6"); idle("R3", "R6");

        // read with a matching operand: hit
        drive(1, 0, 5, m_mem[5], 1); tick("R4", "R6");
        idle("R4", "R6"); idle("R4", "R6");
        chk_q("R4", m_mem[5]); chk_m("R6", 1'b1);

        // read with a mismatching operand: miss
        drive(1, 0, 6, m_mem[6] ^ 18'h1, 1); tick("R4", "R6");
        idle("R4", "R6"); idle("R4", "R6");
        chk_q("R4", m_mem[6]); chk_m("R6", 1'b0);

        // deselected writes in both select encodings are dropped
        w = m_mem[7];
        drive(1, 1, 7, ~w, 1); sel_n = 1; tick("R2", "R7");
        drive(1, 1, 7, ~w, 1); sel_p = 0; tick("R2", "R7");
        drive(1, 0, 7, '0, 0); tick("R2", "R6");
        idle("R2", "R6");
        chk_q("R2", w);

        // write with load strobe off stores the held word
        w = 18'h2A5C3;
        drive(1, 0, 9, w, 1); tick("R5", "R6");
        drive(1, 1, 8, 18'h15A3C, 0); tick("R5", "R6");
        drive(1, 0, 8, '0, 0); tick("R5", "R6");
        idle("R5", "R6");
        chk_q("R5", w);
        idle("R5", "R6");

        // compare right after a write sees the new word
        w = 18'h0F0F1;
        drive(1, 1, 10, w, 1); tick("R8", "R8");
        drive(1, 0, 10, w, 1); tick("R8", "R8");
        idle("R8", "R8"); idle("R8", "R8");
        chk_m("R8", 1'b1);
        // compare inside a write cycle sees the old contents
        drive(1, 1, 11, m_mem[11] ^ 18'h4, 1); tick("R8", "R8");
        idle("R8", "R8"); idle("R8", "R8");
        chk_m("R8", 1'b0);

        // deselected request with matching data gives no hit
        drive(1, 0, 5, m_mem[5], 1); tick("R6", "R6");
        drive(1, 0, 5, m_mem[5], 1); sel_p = 0; tick("R7", "R7");
        idle("R7", "R7");
        chk_m("R7", 1'b1);
        idle("R7", "R7");
        chk_m("R7", 1'b0);

        // unclocked enables
        drive(1, 0, 5, m_mem[5], 1); tick("R9", "R9");
        idle("R9", "R9"); idle("R9", "R9");
        #1 qen_n = 1; #1 chk_q_off("R9"); chk_m("R9", 1'b1);
        men_n = 1; #1 chk_m_off("R9");
        qen_n = 0; men_n = 0; #1 chk_q("R9", m_mem[5]); chk_m("R9", 1'b1);

        // reset keeps the array
        w = m_mem[12];
        rst = 1; idle("R1", "R1");
        rst = 0;
        drive(1, 0, 12, '0, 0); tick("R10", "R6");
        idle("R10", "R6");
        chk_q("R10", w);

        // constrained random traffic
        for (int i = 0; i < 4000; i++) begin
            int a;
            bit sel, wr, ld;
            a   = int'($urandom_range(0, 15));
            sel = ($urandom_range(0, 7) != 0);
            wr  = ($urandom_range(0, 3) == 0);
            ld  = ($urandom_range(0, 3) != 0);
            w   = ($urandom_range(0, 1) == 0) ? m_mem[a] : DW'($urandom);
            drive(sel, wr, a, w, ld);
            if ($urandom_range(0, 1) == 0) sel_n = !sel;
            else sel_p = sel;
            if (!sel && $urandom_range(0, 1) == 0) begin sel_n = 1; sel_p = 1; end
            qen_n = ($urandom_range(0, 9) == 0);
            men_n = ($urandom_range(0, 9) == 0);
            tick("R4", "R6");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule